// File: doc/BRIEF.md
# USB Endpoint Packet Buffer Interface

This block links the byte stream of a USB serial interface engine (SIE) to a 2 Kbyte dual-ported packet memory. The block owns one port of that memory. The CPU reaches the other port through its own path. When the SIE opens a transaction on an endpoint, the block reads that endpoint's descriptor to pick a buffer. A descriptor holds two slots, and each slot is a start address plus a length. The block then moves bytes between the SIE and the memory, one address step per byte. It counts the bytes, holds a receive packet inside its buffer size, and reports the final count when the SIE closes the transaction.

An endpoint whose double-buffer bit is set in its descriptor can run its two slots as a ping-pong pair, provided its kind is bulk or isochronous. In that mode one buffer serves USB while the CPU works on the other. Two toggle bits decide which side holds what. The USB toggle names the slot that the next transaction uses, and it flips after each clean completion. The CPU toggle flips when software releases a buffer. When the two toggles are equal, both buffers belong to the CPU and the transaction is refused.

A CPU register port gives access to every descriptor field and to the toggles. With the default of 10 endpoint numbers, the 20 slots can act as 20 one-way buffers or as 10 double-buffered pairs.

Top module: `usb_pkt_buf_if`

## Requirements
- R1: After reset every descriptor field and both toggles of every endpoint read 0. No response pulse is active and `sie_rd_valid` is low.
- R2: On a single-buffered endpoint, a transmit transaction (`sie_dir_in`=1) uses slot 0 and a receive transaction (`sie_dir_in`=0) uses slot 1.
- R3: The first byte of a transaction goes to or comes from the slot's start address. Each later byte uses the next address, and the address wraps from 2047 to 0.
- R4: When a receive transaction ends with `sie_ok`=1 and no overrun, the received byte count is written into the slot's length field. One cycle after `sie_end`, `xfer_done` pulses with that count on `xfer_cnt`.
- R5: On receive, a byte that arrives once the count has reached the slot's length is not written to memory. The transaction then reports `xfer_ovr`=1, with `xfer_cnt` equal to the length, and the USB toggle does not flip.
- R6: On transmit, each `sie_rd_req` returns the next stored byte on `sie_rd_data` with `sie_rd_valid` one cycle later. `sie_rd_last` marks the byte that reaches the length. A request made after that point gives a one-cycle `sie_rd_eod` pulse and no memory read.
- R7: Double buffering is selected by cfg bit 2 set together with kind bulk (1) or isochronous (3). In that mode the transaction uses the slot named by the USB toggle, and the toggle flips after every clean completion.
- R8: A double-buffered endpoint whose two toggles are equal refuses a transaction. Bulk endpoints answer with a `xact_nak` pulse and isochronous endpoints with a `xact_drop` pulse, one cycle after `sie_start`, and memory is not touched. Writing field 5 with bit 0 set flips the CPU toggle.
- R9: With kind control (0) or interrupt (2), the double-buffer bit has no effect and the endpoint behaves as single-buffered.
- R10: A transaction that ends with `sie_ok`=0 still pulses `xfer_done`, but it neither writes back the count nor flips the USB toggle.
- R11: A `sie_start` naming an endpoint index at or above the endpoint count is answered with `xact_nak`.
- R12: `cpu_addr` carries the endpoint in bits [EPW+2:3] and the field in bits [2:0], and `cpu_rdata` returns the addressed field without delay. The fields are: 0 and 1 for slot 0 address and length, 2 and 3 for slot 1 address and length, 4 for cfg {dbl, kind[1:0]}, and 5 for toggles {usb, cpu}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sie_start | input | 1 | Open a transaction |
| sie_ep | input | EPW | Endpoint index for `sie_start` |
| sie_dir_in | input | 1 | 1 = transmit to host, 0 = receive |
| sie_wr_valid | input | 1 | Receive byte present |
| sie_wr_data | input | 8 | Receive byte |
| sie_rd_req | input | 1 | Request next transmit byte |
| sie_rd_valid | output | 1 | Transmit byte valid |
| sie_rd_data | output | 8 | Transmit byte |
| sie_rd_last | output | 1 | Byte is the final one |
| sie_rd_eod | output | 1 | Request made past end of data |
| sie_end | input | 1 | Close the transaction |
| sie_ok | input | 1 | Transaction succeeded (with `sie_end`) |
| xact_nak | output | 1 | Transaction refused, answer NAK |
| xact_drop | output | 1 | Isochronous transaction discarded |
| xfer_done | output | 1 | Transaction closed |
| xfer_cnt | output | CNT_W | Byte count of the closed transaction |
| xfer_ovr | output | 1 | Receive overrun in the closed transaction |
| mem_addr | output | ADDR_W | Packet memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_re | output | 1 | Memory read strobe (data one cycle later) |
| mem_rdata | input | 8 | Memory read byte |
| cpu_we | input | 1 | Descriptor write strobe |
| cpu_addr | input | EPW+3 | {endpoint, field} |
| cpu_wdata | input | 16 | Descriptor write data |
| cpu_rdata | output | 16 | Descriptor read data |

## Verification
The main function is exercised with a transmit that runs past its length, a short receive, a receive that overflows its buffer, and a receive that wraps past the top of memory. Together these separate correct address stepping, end-of-data signalling, overrun blocking and wrap-around. The double-buffer path is driven through a full ping-pong round on a bulk endpoint, which shows that slot selection follows the USB toggle and that a refused start leaves memory alone. An isochronous endpoint is used to tell drop apart from NAK and to show that an overrun blocks the toggle flip. A control endpoint with the double-buffer bit set, a failed handshake and an out-of-range endpoint each isolate one gating condition.

// File: rtl/pbi_pkg.sv
package pbi_pkg;

  typedef enum logic [1:0] {
    EK_CTRL = 2'd0,
    EK_BULK = 2'd1,
    EK_INTR = 2'd2,
    EK_ISO  = 2'd3
  } ep_kind_e;

  typedef struct packed {
    logic     dbl;
    ep_kind_e kind;
  } ep_cfg_t;

  localparam logic [2:0] FLD_A0  = 3'd0;
  localparam logic [2:0] FLD_N0  = 3'd1;
  localparam logic [2:0] FLD_A1  = 3'd2;
  localparam logic [2:0] FLD_N1  = 3'd3;
  localparam logic [2:0] FLD_CFG = 3'd4;
  localparam logic [2:0] FLD_TOG = 3'd5;

  function automatic logic kind_may_pair(input ep_kind_e k);
    return (k == EK_BULK) || (k == EK_ISO);
  endfunction

endpackage

// File: rtl/pbi_desc_regs.sv
module pbi_desc_regs
  import pbi_pkg::*;
#(
  parameter int N_EP   = 10,
  parameter int EPW    = 4,
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [EPW-1:0]    cpu_ep,
  input  logic [2:0]        cpu_fld,
  input  logic [15:0]       cpu_wdata,
  output logic [15:0]       cpu_rdata,
  input  logic [EPW-1:0]    lk_ep,
  output logic              lk_valid,
  output ep_cfg_t           lk_cfg,
  output logic              lk_utog,
  output logic              lk_ctog,
  output logic [ADDR_W-1:0] lk_a0,
  output logic [CNT_W-1:0]  lk_n0,
  output logic [ADDR_W-1:0] lk_a1,
  output logic [CNT_W-1:0]  lk_n1,
  input  logic              wb_en,
  input  logic [EPW-1:0]    wb_ep,
  input  logic              wb_slot,
  input  logic [CNT_W-1:0]  wb_cnt,
  input  logic              flip_en,
  input  logic [EPW-1:0]    flip_ep
);

  logic [N_EP-1:0][ADDR_W-1:0] a0_all, a1_all;
  logic [N_EP-1:0][CNT_W-1:0]  n0_all, n1_all;
  logic [N_EP-1:0][2:0]        cfg_all;
  logic [N_EP-1:0]             utog_all, ctog_all;

  wire unused_wdata = &{1'b0, cpu_wdata};

  function automatic logic ep_in_range(input logic [EPW-1:0] e);
    return int'(e) < N_EP;
  endfunction

  for (genvar e = 0; e < N_EP; e++) begin : g_ep
    logic [ADDR_W-1:0] a0_q, a1_q;
    logic [CNT_W-1:0]  n0_q, n1_q;
    ep_cfg_t           cfg_q;
    logic              utog_q, ctog_q;
    wire cpu_hit  = cpu_we  && (cpu_ep  == EPW'(e));
    wire wb_hit   = wb_en   && (wb_ep   == EPW'(e));
    wire flip_hit = flip_en && (flip_ep == EPW'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a0_q   <= '0;
        a1_q   <= '0;
        n0_q   <= '0;
        n1_q   <= '0;
        cfg_q  <= '0;
        utog_q <= 1'b0;
        ctog_q <= 1'b0;
      end else begin
        if (cpu_hit) begin
          case (cpu_fld)
            FLD_A0:  a0_q  <= cpu_wdata[ADDR_W-1:0];
            FLD_N0:  n0_q  <= cpu_wdata[CNT_W-1:0];
            FLD_A1:  a1_q  <= cpu_wdata[ADDR_W-1:0];
            FLD_N1:  n1_q  <= cpu_wdata[CNT_W-1:0];
            FLD_CFG: cfg_q <= ep_cfg_t'(cpu_wdata[2:0]);
            FLD_TOG: if (cpu_wdata[0]) ctog_q <= ~ctog_q;
            default: ;
          endcase
        end
        // hardware write-back takes precedence over a same-cycle CPU write
        if (wb_hit && !wb_slot) n0_q <= wb_cnt;
        if (wb_hit &&  wb_slot) n1_q <= wb_cnt;
        if (flip_hit) utog_q <= ~utog_q;
      end
    end

    assign a0_all[e]   = a0_q;
    assign a1_all[e]   = a1_q;
    assign n0_all[e]   = n0_q;
    assign n1_all[e]   = n1_q;
    assign cfg_all[e]  = cfg_q;
    assign utog_all[e] = utog_q;
    assign ctog_all[e] = ctog_q;
  end

  logic [EPW-1:0] lk_idx, cpu_idx;
  logic           cpu_ok;

  always_comb begin
    lk_valid = ep_in_range(lk_ep);
    lk_idx   = lk_valid ? lk_ep : '0;
    lk_cfg   = lk_valid ? ep_cfg_t'(cfg_all[lk_idx]) : '0;
    lk_utog  = lk_valid & utog_all[lk_idx];
    lk_ctog  = lk_valid & ctog_all[lk_idx];
    lk_a0    = a0_all[lk_idx];
    lk_n0    = n0_all[lk_idx];
    lk_a1    = a1_all[lk_idx];
    lk_n1    = n1_all[lk_idx];
  end

  always_comb begin
    cpu_ok    = ep_in_range(cpu_ep);
    cpu_idx   = cpu_ok ? cpu_ep : '0;
    cpu_rdata = '0;
    if (cpu_ok) begin
      case (cpu_fld)
        FLD_A0:  cpu_rdata = 16'(a0_all[cpu_idx]);
        FLD_N0:  cpu_rdata = 16'(n0_all[cpu_idx]);
        FLD_A1:  cpu_rdata = 16'(a1_all[cpu_idx]);
        FLD_N1:  cpu_rdata = 16'(n1_all[cpu_idx]);
        FLD_CFG: cpu_rdata = 16'(cfg_all[cpu_idx]);
        FLD_TOG: cpu_rdata = 16'({utog_all[cpu_idx], ctog_all[cpu_idx]});
        default: cpu_rdata = '0;
      endcase
    end
  end

  // R7: the USB toggle moves only when the stream engine asks for it
  a_r7_utog_only_on_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (utog_all != $past(utog_all)) |-> $past(flip_en));

  // R8: the CPU toggle moves only on a toggle-field write
  a_r8_ctog_only_on_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    (ctog_all != $past(ctog_all)) |-> $past(cpu_we && (cpu_fld == FLD_TOG)));

endmodule

// File: rtl/pbi_route.sv
module pbi_route
  import pbi_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 11
) (
  input  logic              ep_valid,
  input  logic              dir_in,
  input  ep_cfg_t           cfg,
  input  logic              utog,
  input  logic              ctog,
  input  logic [ADDR_W-1:0] a0,
  input  logic [CNT_W-1:0]  n0,
  input  logic [ADDR_W-1:0] a1,
  input  logic [CNT_W-1:0]  n1,
  output logic              paired,
  output logic              slot,
  output logic              held,
  output logic              quiet,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  lim
);

  always_comb begin
    paired = ep_valid && cfg.dbl && kind_may_pair(cfg.kind);
    // ping-pong endpoints follow the USB toggle; others split by direction
    slot   = paired ? utog : ~dir_in;
    held   = !ep_valid || (paired && (utog == ctog));
    quiet  = held && ep_valid && (cfg.kind == EK_ISO);
    addr   = slot ? a1 : a0;
    lim    = slot ? n1 : n0;
  end

endmodule

// File: rtl/pbi_stream.sv
module pbi_stream #(
  parameter int EPW    = 4,
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sie_start,
  input  logic [EPW-1:0]    sie_ep,
  input  logic              sie_dir_in,
  input  logic              sie_wr_valid,
  input  logic [7:0]        sie_wr_data,
  input  logic              sie_rd_req,
  input  logic              sie_end,
  input  logic              sie_ok,
  input  logic              rt_held,
  input  logic              rt_quiet,
  input  logic              rt_paired,
  input  logic              rt_slot,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic [CNT_W-1:0]  rt_lim,
  output logic              sie_rd_valid,
  output logic [7:0]        sie_rd_data,
  output logic              sie_rd_last,
  output logic              sie_rd_eod,
  output logic              xact_nak,
  output logic              xact_drop,
  output logic              xfer_done,
  output logic [CNT_W-1:0]  xfer_cnt,
  output logic              xfer_ovr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata,
  output logic              wb_en,
  output logic [EPW-1:0]    wb_ep,
  output logic              wb_slot,
  output logic [CNT_W-1:0]  wb_cnt,
  output logic              flip_en,
  output logic [EPW-1:0]    flip_ep
);

  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_TX} st_e;

  st_e               st_q;
  logic [EPW-1:0]    ep_q;
  logic              slot_q, paired_q, ovr_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [CNT_W-1:0]  lim_q, cnt_q, dcnt_q;
  logic              rv_q, last_q, eod_q, nak_q, drop_q, done_q, dovr_q;

  function automatic logic has_room(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] l);
    return c < l;
  endfunction

  function automatic logic is_final(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] l);
    return (c + CNT_W'(1)) == l;
  endfunction

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  // named internal events
  logic start_ok, take_wr, take_rd, room, ovr_hit, eod_hit, finish, clean_end;

  always_comb begin
    start_ok  = (st_q == ST_IDLE) && sie_start;
    room      = has_room(cnt_q, lim_q);
    take_wr   = (st_q == ST_RX) && sie_wr_valid && !sie_end;
    take_rd   = (st_q == ST_TX) && sie_rd_req && !sie_end;
    ovr_hit   = take_wr && !room;
    eod_hit   = take_rd && !room;
    finish    = (st_q != ST_IDLE) && sie_end;
    clean_end = finish && sie_ok && !ovr_q;
  end

  assign mem_addr  = ptr_q;
  assign mem_wdata = sie_wr_data;
  assign mem_we    = take_wr && room;
  assign mem_re    = take_rd && room;

  assign wb_en   = clean_end && (st_q == ST_RX);
  assign wb_ep   = ep_q;
  assign wb_slot = slot_q;
  assign wb_cnt  = cnt_q;
  assign flip_en = clean_end && paired_q;
  assign flip_ep = ep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ep_q     <= '0;
      slot_q   <= 1'b0;
      paired_q <= 1'b0;
      ovr_q    <= 1'b0;
      ptr_q    <= '0;
      lim_q    <= '0;
      cnt_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_ok && !rt_held) begin
            st_q     <= sie_dir_in ? ST_TX : ST_RX;
            ep_q     <= sie_ep;
            slot_q   <= rt_slot;
            paired_q <= rt_paired;
            ptr_q    <= rt_addr;
            lim_q    <= rt_lim;
            cnt_q    <= '0;
            ovr_q    <= 1'b0;
          end
        end
        default: begin
          if (finish) begin
            st_q <= ST_IDLE;
          end else begin
            if (mem_we || mem_re) begin
              ptr_q <= next_addr(ptr_q);
              cnt_q <= cnt_q + CNT_W'(1);
            end
            if (ovr_hit) ovr_q <= 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q   <= 1'b0;
      last_q <= 1'b0;
      eod_q  <= 1'b0;
      nak_q  <= 1'b0;
      drop_q <= 1'b0;
      done_q <= 1'b0;
      dcnt_q <= '0;
      dovr_q <= 1'b0;
    end else begin
      rv_q   <= mem_re;
      last_q <= mem_re && is_final(cnt_q, lim_q);
      eod_q  <= eod_hit;
      nak_q  <= start_ok && rt_held && !rt_quiet;
      drop_q <= start_ok && rt_held && rt_quiet;
      done_q <= finish;
      if (finish) begin
        dcnt_q <= cnt_q;
        dovr_q <= ovr_q;
      end
    end
  end

  assign sie_rd_valid = rv_q;
  assign sie_rd_data  = rv_q ? mem_rdata : 8'h00;
  assign sie_rd_last  = last_q;
  assign sie_rd_eod   = eod_q;
  assign xact_nak     = nak_q;
  assign xact_drop    = drop_q;
  assign xfer_done    = done_q;
  assign xfer_cnt     = dcnt_q;
  assign xfer_ovr     = dovr_q;

  // R3: each memory access moves the pointer one step, wrapping at the top
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |=> (ptr_q == ADDR_W'($past(ptr_q) + ADDR_W'(1))));

  // R5: once an overrun is recorded no further byte reaches memory
  a_r5_ovr_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> !mem_we);

  // R4: the running count never exceeds the slot length
  a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> (cnt_q <= lim_q));

  // R8: a refused start leaves the engine idle and memory quiet
  a_r8_refusal_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (xact_nak || xact_drop) |-> ((st_q == ST_IDLE) && !mem_we && !mem_re));

  // R8: a transaction has at most one kind of closing response
  a_r8_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xact_nak, xact_drop, xfer_done}));

endmodule

// File: rtl/usb_pkt_buf_if.sv
module usb_pkt_buf_if
  import pbi_pkg::*;
#(
  parameter  int N_EP   = 10,
  parameter  int ADDR_W = 11,
  localparam int EPW    = $clog2(N_EP),
  localparam int CNT_W  = ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sie_start,
  input  logic [EPW-1:0]    sie_ep,
  input  logic              sie_dir_in,
  input  logic              sie_wr_valid,
  input  logic [7:0]        sie_wr_data,
  input  logic              sie_rd_req,
  output logic              sie_rd_valid,
  output logic [7:0]        sie_rd_data,
  output logic              sie_rd_last,
  output logic              sie_rd_eod,
  input  logic              sie_end,
  input  logic              sie_ok,
  output logic              xact_nak,
  output logic              xact_drop,
  output logic              xfer_done,
  output logic [CNT_W-1:0]  xfer_cnt,
  output logic              xfer_ovr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata,
  input  logic              cpu_we,
  input  logic [EPW+2:0]    cpu_addr,
  input  logic [15:0]       cpu_wdata,
  output logic [15:0]       cpu_rdata
);

  logic              lk_valid, lk_utog, lk_ctog;
  ep_cfg_t           lk_cfg;
  logic [ADDR_W-1:0] lk_a0, lk_a1, rt_addr;
  logic [CNT_W-1:0]  lk_n0, lk_n1, rt_lim, wb_cnt;
  logic              rt_paired, rt_slot, rt_held, rt_quiet;
  logic              wb_en, wb_slot, flip_en;
  logic [EPW-1:0]    wb_ep, flip_ep;

  pbi_desc_regs #(.N_EP(N_EP), .EPW(EPW), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) desc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_we   (cpu_we),
    .cpu_ep   (cpu_addr[EPW+2:3]),
    .cpu_fld  (cpu_addr[2:0]),
    .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata),
    .lk_ep    (sie_ep),
    .lk_valid (lk_valid),
    .lk_cfg   (lk_cfg),
    .lk_utog  (lk_utog),
    .lk_ctog  (lk_ctog),
    .lk_a0    (lk_a0),
    .lk_n0    (lk_n0),
    .lk_a1    (lk_a1),
    .lk_n1    (lk_n1),
    .wb_en    (wb_en),
    .wb_ep    (wb_ep),
    .wb_slot  (wb_slot),
    .wb_cnt   (wb_cnt),
    .flip_en  (flip_en),
    .flip_ep  (flip_ep)
  );

  pbi_route #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) route_i (
    .ep_valid(lk_valid),
    .dir_in  (sie_dir_in),
    .cfg     (lk_cfg),
    .utog    (lk_utog),
    .ctog    (lk_ctog),
    .a0      (lk_a0),
    .n0      (lk_n0),
    .a1      (lk_a1),
    .n1      (lk_n1),
    .paired  (rt_paired),
    .slot    (rt_slot),
    .held    (rt_held),
    .quiet   (rt_quiet),
    .addr    (rt_addr),
    .lim     (rt_lim)
  );

  pbi_stream #(.EPW(EPW), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) stream_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sie_start   (sie_start),
    .sie_ep      (sie_ep),
    .sie_dir_in  (sie_dir_in),
    .sie_wr_valid(sie_wr_valid),
    .sie_wr_data (sie_wr_data),
    .sie_rd_req  (sie_rd_req),
    .sie_end     (sie_end),
    .sie_ok      (sie_ok),
    .rt_held     (rt_held),
    .rt_quiet    (rt_quiet),
    .rt_paired   (rt_paired),
    .rt_slot     (rt_slot),
    .rt_addr     (rt_addr),
    .rt_lim      (rt_lim),
    .sie_rd_valid(sie_rd_valid),
    .sie_rd_data (sie_rd_data),
    .sie_rd_last (sie_rd_last),
    .sie_rd_eod  (sie_rd_eod),
    .xact_nak    (xact_nak),
    .xact_drop   (xact_drop),
    .xfer_done   (xfer_done),
    .xfer_cnt    (xfer_cnt),
    .xfer_ovr    (xfer_ovr),
    .mem_addr    (mem_addr),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata),
    .mem_re      (mem_re),
    .mem_rdata   (mem_rdata),
    .wb_en       (wb_en),
    .wb_ep       (wb_ep),
    .wb_slot     (wb_slot),
    .wb_cnt      (wb_cnt),
    .flip_en     (flip_en),
    .flip_ep     (flip_ep)
  );

endmodule

// File: tb/usb_pkt_buf_if_tb_top.sv
module usb_pkt_buf_if_tb_top;

  localparam int EPW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sie_start = 0, sie_dir_in = 0, sie_wr_valid = 0, sie_rd_req = 0;
  logic        sie_end = 0, sie_ok = 0, cpu_we = 0;
  logic [3:0]  sie_ep = '0;
  logic [7:0]  sie_wr_data = '0;
  logic [6:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        sie_rd_valid, sie_rd_last, sie_rd_eod, xact_nak, xact_drop, xfer_done, xfer_ovr;
  logic [7:0]  sie_rd_data, mem_wdata;
  logic [10:0] xfer_cnt, mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] cpu_rdata;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  usb_pkt_buf_if dut_i (
    .clk(clk), .rst_n(rst_n),
    .sie_start(sie_start), .sie_ep(sie_ep), .sie_dir_in(sie_dir_in),
    .sie_wr_valid(sie_wr_valid), .sie_wr_data(sie_wr_data),
    .sie_rd_req(sie_rd_req), .sie_rd_valid(sie_rd_valid), .sie_rd_data(sie_rd_data),
    .sie_rd_last(sie_rd_last), .sie_rd_eod(sie_rd_eod),
    .sie_end(sie_end), .sie_ok(sie_ok),
    .xact_nak(xact_nak), .xact_drop(xact_drop), .xfer_done(xfer_done),
    .xfer_cnt(xfer_cnt), .xfer_ovr(xfer_ovr),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_rdata(mem_rdata),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  // packet memory model: filled with a known pattern during reset
  logic [7:0] mem [0:2047];
  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'h3C;
  endfunction
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2048; i++) mem[i] <= pat(i);
    end else begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr];
    end
  end

  // scoreboard: tag in [31:28], payload below
  logic [31:0] exp_q[$];
  string       req_q[$];

  function automatic logic [31:0] ev(input logic [3:0] tag, input logic [27:0] pl);
    return {tag, pl};
  endfunction
  function automatic logic [31:0] ev_data(input logic [7:0] b, input logic last);
    return ev(4'd1, {19'd0, last, b});
  endfunction
  function automatic logic [31:0] ev_done(input int cnt, input logic ovr);
    return ev(4'd3, {16'd0, ovr, 11'(cnt)});
  endfunction

  task automatic expect_ev(input logic [31:0] v, input string r);
    exp_q.push_back(v);
    req_q.push_back(r);
  endtask

  task automatic sb_take(input logic [31:0] obs);
    logic [31:0] e;
    string r;
    compared++;
    if (exp_q.size() == 0) begin
      mismatched++;
      $display("FAIL unexpected event: actual %h expected none", obs);
    end else begin
      e = exp_q.pop_front();
      r = req_q.pop_front();
      if (e !== obs) begin
        mismatched++;
        $display("FAIL %s event: actual %h expected %h", r, obs, e);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (sie_rd_valid) sb_take(ev_data(sie_rd_data, sie_rd_last));
      if (sie_rd_eod)   sb_take(ev(4'd2, '0));
      if (xfer_done)    sb_take(ev_done(int'(xfer_cnt), xfer_ovr));
      if (xact_nak)     sb_take(ev(4'd4, '0));
      if (xact_drop)    sb_take(ev(4'd5, '0));
    end
  end

  task automatic check(input int act, input int expv, input string r);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", r, act, expv);
    end
  endtask

  task automatic cpu_wr(input int ep, input int fld, input int d);
    cpu_we = 1; cpu_addr = {4'(ep), 3'(fld)}; cpu_wdata = 16'(d);
    @(negedge clk);
    cpu_we = 0;
  endtask

  task automatic cpu_chk(input int ep, input int fld, input int expv, input string r);
    cpu_addr = {4'(ep), 3'(fld)};
    #1;
    check(int'(cpu_rdata), expv, r);
  endtask

  task automatic go(input int ep, input logic din);
    sie_start = 1; sie_ep = 4'(ep); sie_dir_in = din;
    @(negedge clk);
    sie_start = 0;
  endtask

  task automatic put(input logic [7:0] b);
    sie_wr_valid = 1; sie_wr_data = b;
    @(negedge clk);
    sie_wr_valid = 0;
  endtask

  task automatic pull();
    sie_rd_req = 1;
    @(negedge clk);
    sie_rd_req = 0;
  endtask

  task automatic fin(input logic ok);
    sie_end = 1; sie_ok = ok;
    @(negedge clk);
    sie_end = 0; sie_ok = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    cpu_chk(0, 0, 0, "R1 slot0 addr");
    cpu_chk(1, 3, 0, "R1 slot1 len");
    cpu_chk(3, 5, 0, "R1 toggles");
    check(int'({sie_rd_valid, xfer_done, xact_nak, xact_drop}), 0, "R1 outputs idle");

    // single-buffered endpoint 1
    cpu_wr(1, 0, 'h100); cpu_wr(1, 1, 4);
    cpu_wr(1, 2, 'h200); cpu_wr(1, 3, 3);
    cpu_chk(1, 2, 'h200, "R12 slot1 addr readback");

    // R2 R3 R6 transmit through slot 0, one request past the end
    for (int i = 0; i < 4; i++) expect_ev(ev_data(pat('h100 + i), i == 3), "R6 tx byte");
    expect_ev(ev(4'd2, '0), "R6 end of data");
    expect_ev(ev_done(4, 0), "R2 tx done");
    go(1, 1);
    for (int i = 0; i < 5; i++) pull();
    fin(1);

    // R2 R4 receive into slot 1 with count write-back
    expect_ev(ev_done(2, 0), "R4 rx done");
    go(1, 0); put(8'h11); put(8'h22); fin(1);
    check(int'(mem['h200]), 'h11, "R2 rx byte0");
    check(int'(mem['h201]), 'h22, "R3 rx byte1");
    cpu_chk(1, 3, 2, "R4 count write-back");

    // R5 overrun: size 3, five bytes offered
    cpu_wr(1, 3, 3);
    expect_ev(ev_done(3, 1), "R5 overrun done");
    go(1, 0);
    for (int i = 0; i < 5; i++) put(8'(8'h31 + i));
    fin(1);
    check(int'(mem['h202]), 'h33, "R5 last fitting byte");
    check(int'(mem['h203]), int'(pat('h203)), "R5 no write past size");

    // R3 wrap at top of memory
    cpu_wr(2, 2, 'h7FE); cpu_wr(2, 3, 4);
    expect_ev(ev_done(3, 0), "R3 wrap done");
    go(2, 0); put(8'h41); put(8'h42); put(8'h43); fin(1);
    check(int'(mem['h7FF]), 'h42, "R3 top byte");
    check(int'(mem[0]), 'h43, "R3 wrapped byte");

    // R7 R8 bulk ping-pong on endpoint 3
    cpu_wr(3, 0, 'h300); cpu_wr(3, 1, 8);
    cpu_wr(3, 2, 'h380); cpu_wr(3, 3, 8);
    cpu_wr(3, 4, 'b101);
    cpu_chk(3, 4, 'b101, "R12 cfg readback");
    expect_ev(ev(4'd4, '0), "R8 bulk held nak");
    go(3, 0); put(8'h99); repeat (2) @(negedge clk);
    check(int'(mem['h300]), int'(pat('h300)), "R8 held no write");
    cpu_wr(3, 5, 1);
    cpu_chk(3, 5, 1, "R8 cpu toggle flips");
    expect_ev(ev_done(2, 0), "R7 first buffer done");
    go(3, 0); put(8'h51); put(8'h52); fin(1);
    check(int'(mem['h300]), 'h51, "R7 slot0 used first");
    cpu_chk(3, 5, 3, "R7 usb toggle flipped");
    expect_ev(ev(4'd4, '0), "R8 both cpu owned nak");
    go(3, 0); repeat (2) @(negedge clk);
    cpu_wr(3, 5, 1);
    expect_ev(ev_done(1, 0), "R7 second buffer done");
    go(3, 0); put(8'h61); fin(1);
    check(int'(mem['h380]), 'h61, "R7 slot1 used second");
    cpu_chk(3, 3, 1, "R4 slot1 write-back");
    cpu_chk(3, 5, 0, "R7 toggles after round");

    // R8 R5 isochronous endpoint 4
    cpu_wr(4, 0, 'h400); cpu_wr(4, 1, 1);
    cpu_wr(4, 2, 'h480); cpu_wr(4, 3, 8);
    cpu_wr(4, 4, 'b111);
    expect_ev(ev(4'd5, '0), "R8 iso drop");
    go(4, 0); repeat (2) @(negedge clk);
    cpu_wr(4, 5, 1);
    expect_ev(ev_done(1, 1), "R5 iso overrun done");
    go(4, 0); put(8'h71); put(8'h72); fin(1);
    check(int'(mem['h401]), int'(pat('h401)), "R5 iso no write past size");
    cpu_chk(4, 5, 1, "R5 no flip on overrun");

    // R10 failed handshake
    cpu_wr(4, 1, 4);
    expect_ev(ev_done(1, 0), "R10 failed done");
    go(4, 0); put(8'h73); fin(0);
    cpu_chk(4, 1, 4, "R10 no write-back");
    cpu_chk(4, 5, 1, "R10 no flip");

    // R9 double bit ignored on control kind
    cpu_wr(5, 2, 'h500); cpu_wr(5, 3, 2); cpu_wr(5, 4, 'b100);
    expect_ev(ev_done(1, 0), "R9 ctrl single done");
    go(5, 0); put(8'h81); fin(1);
    check(int'(mem['h500]), 'h81, "R9 slot1 used");
    cpu_chk(5, 5, 0, "R9 toggles untouched");

    // R11 endpoint out of range
    expect_ev(ev(4'd4, '0), "R11 bad endpoint nak");
    go(12, 0); repeat (3) @(negedge clk);
    cpu_chk(12, 0, 0, "R12 out-of-range read");

    repeat (3) @(negedge clk);
    check(exp_q.size(), 0, "R6 all expected events seen");
    report();
  end

endmodule